// File: doc/BRIEF.md
# Wide-Fetch Streaming Buffer

This block is a stream buffer that behaves like a memory with two write ports and two read ports. All four ports share one single-port SRAM whose every access moves a wide word of `FW` data words. Each of the four ports owns an affine address generator. Writers push plain word streams and never supply an address. Readers receive word streams that the buffer pushes out on its own, with no address input.

On a write port, words gather in an aggregation register. When `FW` words are present, the port requests one wide SRAM write to its next generated address. On a read port, an empty split register requests one wide SRAM read. The wide word is then handed out one data word per handshake. A rotating arbiter gives the single SRAM port to one pending request per cycle.

Each generator walks up to three nested loops. Every loop has its own extent and stride, and the walk starts from a configured offset. The generator advances once per wide access. After its final iteration the port goes quiet until the next reset. Reset clears all control state but leaves the SRAM contents intact, so one configuration can fill the storage and a later one can drain it.

Top module: `wf_push_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it falls, both write ports show ready, neither read port shows valid and all four done flags are low. Reset does not alter the stored data.
- R2: A write port packs `FW` consecutive accepted words into one wide word. The first accepted word goes to lane 0 (bits `DW-1:0`) and lane k sits at bits `k*DW +: DW`. The wide word is written at the port's current generated address.
- R3: A write port drops ready while its aggregation register is full and not granted. It never holds more than `FW` words. In a cycle where it is granted, it may accept the first word of the next group.
- R4: A read port requests a wide read only when its split register is empty and no fetch is in flight. It then emits lanes 0 to `FW-1` in order, one per handshake, with no address input.
- R5: While a read port shows valid and its ready is low, valid stays high and the data word stays unchanged in the next cycle.
- R6: Each generator produces the address start + i0*s0 + i1*s1 + i2*s2 modulo the depth, with loop 0 innermost and each index i running from 0 to its extent minus 1. A stride written as its two's complement modulo the depth walks backwards. The generator advances by exactly one iteration per granted wide access.
- R7: After extent0*extent1*extent2 wide accesses, a port's done flag goes high and stays high until reset. Done bits are ordered write0, write1, read0, read1 from bit 0. A finished write port keeps ready low. A finished read port fetches nothing more and shows no valid once its last wide word has been emitted.
- R8: The SRAM sees at most one access per cycle. A grant goes only to a requesting port, and a grant is issued whenever at least one port requests. Both write streams and both read streams therefore complete while sharing the port.
- R9: Arbitration order is write0, write1, read0, read1. After port i is granted, the search for the next grant starts at port i+1, wrapping from read1 to write0. While reset is high, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 4*ADDR_W | Start offset per generator, slot order write0, write1, read0, read1 |
| cfg_ext | input | 4*3*EXT_W | Loop extents per generator, loop 0 in the low field of each slot |
| cfg_stride | input | 4*3*ADDR_W | Loop strides per generator, modulo depth, loop 0 in the low field |
| wr_valid | input | 2 | Write stream valid, bit per write port |
| wr_data | input | 2*DW | Write stream words, port p at bits `p*DW +: DW` |
| wr_ready | output | 2 | Write stream ready |
| rd_valid | output | 2 | Read stream valid |
| rd_data | output | 2*DW | Read stream words, port p at bits `p*DW +: DW` |
| rd_ready | input | 2 | Read stream ready |
| port_done | output | 4 | Generator finished flags: write0, write1, read0, read1 |

## Verification
The bench targets the cycle where both write ports fill together. A wrong arbiter order or a missing grant bypass would show the wrong ready pattern there, or would stall a stream for good. It reads one region back in written order and the other with negative strides. A generator that ignored strides, carried between loops wrongly, or did not wrap modulo the depth would return words from the wrong wide slots. A split register that shifted the wrong way would return lanes in reverse. It throttles one reader to catch data that moves under backpressure. It drives both kinds of port after they finish, to catch an extra word accepted on the final grant or an extra fetch after done.

// File: rtl/wfpb_pkg.sv
package wfpb_pkg;
  localparam int NUM_WR    = 2;
  localparam int NUM_RD    = 2;
  localparam int NUM_PORTS = NUM_WR + NUM_RD;
  localparam int NLOOP     = 3;

  // Arbitration slot of each logical port; the order is the priority order.
  typedef enum logic [1:0] {
    SLOT_WR0 = 2'd0,
    SLOT_WR1 = 2'd1,
    SLOT_RD0 = 2'd2,
    SLOT_RD1 = 2'd3
  } slot_e;
endpackage

// File: rtl/wfpb_addr_gen.sv
module wfpb_addr_gen #(
  parameter int ADDR_W = 9,
  parameter int EXT_W  = 8,
  parameter int NLOOP  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic [ADDR_W-1:0]        cfg_start,
  input  logic [NLOOP*EXT_W-1:0]   cfg_ext,
  input  logic [NLOOP*ADDR_W-1:0]  cfg_stride,
  output logic [ADDR_W-1:0]        addr,
  output logic                     last,
  output logic                     done
);
  logic [EXT_W-1:0]  idx_q [NLOOP];
  logic [ADDR_W-1:0] off_q [NLOOP];
  logic [NLOOP-1:0]  at_end;
  logic [NLOOP:0]    carry;
  logic              done_q;

  // A level is at its end when the next index would reach the extent (extent 0 acts as 1).
  always_comb begin
    for (int l = 0; l < NLOOP; l++) begin
      at_end[l] = (({1'b0, idx_q[l]} + (EXT_W+1)'(1)) >= {1'b0, cfg_ext[l*EXT_W +: EXT_W]});
    end
    carry[0] = step && !done_q;
    for (int l = 0; l < NLOOP; l++) begin
      carry[l+1] = carry[l] && at_end[l];
    end
  end

  always_comb begin
    addr = cfg_start;
    for (int l = 0; l < NLOOP; l++) begin
      addr = addr + off_q[l];
    end
  end

  assign last = &at_end;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      for (int l = 0; l < NLOOP; l++) begin
        idx_q[l] <= '0;
        off_q[l] <= '0;
      end
    end else if (carry[NLOOP]) begin
      done_q <= 1'b1;
    end else begin
      for (int l = 0; l < NLOOP; l++) begin
        if (carry[l]) begin
          if (at_end[l]) begin
            idx_q[l] <= '0;
            off_q[l] <= '0;
          end else begin
            idx_q[l] <= idx_q[l] + EXT_W'(1);
            off_q[l] <= off_q[l] + cfg_stride[l*ADDR_W +: ADDR_W];
          end
        end
      end
    end
  end

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_addr_moves_only_on_step_R6: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr));
endmodule

// File: rtl/wfpb_wr_port.sv
module wfpb_wr_port #(
  parameter int DW = 16,
  parameter int FW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  input  logic            gnt,
  input  logic            gen_last,
  input  logic            gen_done,
  output logic            req,
  output logic [FW*DW-1:0] wide
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] FULL_C = CW'(FW);

  logic [FW*DW-1:0] agg_q;
  logic [CW-1:0]    cnt_q;
  logic             full;
  logic             accept;
  logic [CW-1:0]    slot;

  assign full     = (cnt_q == FULL_C);
  assign req      = full && !gen_done;
  // On a grant the register drains this cycle, so one new word may enter,
  // except on the final wide write of the pattern.
  assign in_ready = !gen_done && (!full || (gnt && !gen_last));
  assign accept   = in_valid && in_ready;
  assign slot     = gnt ? '0 : cnt_q;
  assign wide     = agg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (gnt) begin
      cnt_q <= accept ? CW'(1) : '0;
    end else if (accept) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < FW; k++) begin
      if (accept && slot == CW'(k)) begin
        agg_q[k*DW +: DW] <= in_data;
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_C);
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (full && !gnt) |=> $stable(agg_q));
  assert_grant_only_when_full_R2: assert property (@(posedge clk) disable iff (rst)
    gnt |-> full);
endmodule

// File: rtl/wfpb_rd_port.sv
module wfpb_rd_port #(
  parameter int DW = 16,
  parameter int FW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gnt,
  input  logic             gen_done,
  input  logic [FW*DW-1:0] sram_q,
  output logic             req,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  input  logic             out_ready
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] FULL_C = CW'(FW);

  logic [FW*DW-1:0] buf_q;
  logic [CW-1:0]    cnt_q;
  logic             pend_q;

  assign req       = (cnt_q == '0) && !pend_q && !gen_done;
  assign out_valid = (cnt_q != '0);
  assign out_data  = buf_q[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= gnt;
      if (pend_q) begin
        cnt_q <= FULL_C;
      end else if (out_valid && out_ready) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q) begin
      buf_q <= sram_q;
    end else if (out_valid && out_ready) begin
      buf_q <= {{DW{1'b0}}, buf_q[FW*DW-1:DW]};
    end
  end

  assert_hold_under_backpressure_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_fetch_only_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    gnt |-> (cnt_q == '0 && !pend_q));
  assert_no_fetch_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    gen_done |-> !gnt);
endmodule

// File: rtl/wfpb_arbiter.sv
module wfpb_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] gidx;
  logic          found;

  always_comb begin
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!rst && !found && req[(int'(ptr_q) + k) % N]) begin
        gnt[(int'(ptr_q) + k) % N] = 1'b1;
        gidx  = PW'((int'(ptr_q) + k) % N);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + PW'(1);
    end
  end

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_grant_to_requester_R8: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  assert_work_conserving_R8: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|gnt));

  for (genvar i = 0; i < N; i++) begin : g_rot
    localparam int NEXT = (i + 1) % N;
    assert_rotate_R9: assert property (@(posedge clk) disable iff (rst)
      (req[NEXT] && $past(gnt[i])) |-> gnt[NEXT]);
  end
endmodule

// File: rtl/wf_push_buffer.sv
module wf_push_buffer
  import wfpb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FW    = 4,
  parameter int DEPTH = 512,
  parameter int EXT_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WW     = DW * FW
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_PORTS*ADDR_W-1:0]       cfg_start,
  input  logic [NUM_PORTS*NLOOP*EXT_W-1:0]  cfg_ext,
  input  logic [NUM_PORTS*NLOOP*ADDR_W-1:0] cfg_stride,
  input  logic [NUM_WR-1:0]                 wr_valid,
  input  logic [NUM_WR*DW-1:0]              wr_data,
  output logic [NUM_WR-1:0]                 wr_ready,
  output logic [NUM_RD-1:0]                 rd_valid,
  output logic [NUM_RD*DW-1:0]              rd_data,
  input  logic [NUM_RD-1:0]                 rd_ready,
  output logic [NUM_PORTS-1:0]              port_done
);
  logic [NUM_PORTS-1:0] req;
  logic [NUM_PORTS-1:0] gnt;
  logic [NUM_PORTS-1:0] gen_done;
  logic [ADDR_W-1:0]    gen_addr [NUM_PORTS];
  logic                 wr_last [NUM_WR];
  logic                 rd_last_unused [NUM_RD];
  logic [WW-1:0]        wr_wide [NUM_WR];

  logic                 sram_en;
  logic                 sram_we;
  logic [ADDR_W-1:0]    sram_addr;
  logic [WW-1:0]        sram_wdata;
  logic [WW-1:0]        sram_q;
  logic [WW-1:0]        mem_q [DEPTH];

  wfpb_arbiter #(.N(NUM_PORTS)) arb_i (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
  );

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
    wfpb_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .NLOOP(NLOOP)) gen_i (
      .clk        (clk),
      .rst        (rst),
      .step       (gnt[w]),
      .cfg_start  (cfg_start[w*ADDR_W +: ADDR_W]),
      .cfg_ext    (cfg_ext[w*NLOOP*EXT_W +: NLOOP*EXT_W]),
      .cfg_stride (cfg_stride[w*NLOOP*ADDR_W +: NLOOP*ADDR_W]),
      .addr       (gen_addr[w]),
      .last       (wr_last[w]),
      .done       (gen_done[w])
    );
    wfpb_wr_port #(.DW(DW), .FW(FW)) port_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (wr_valid[w]),
      .in_data  (wr_data[w*DW +: DW]),
      .in_ready (wr_ready[w]),
      .gnt      (gnt[w]),
      .gen_last (wr_last[w]),
      .gen_done (gen_done[w]),
      .req      (req[w]),
      .wide     (wr_wide[w])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    localparam int P = NUM_WR + r;
    wfpb_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .NLOOP(NLOOP)) gen_i (
      .clk        (clk),
      .rst        (rst),
      .step       (gnt[P]),
      .cfg_start  (cfg_start[P*ADDR_W +: ADDR_W]),
      .cfg_ext    (cfg_ext[P*NLOOP*EXT_W +: NLOOP*EXT_W]),
      .cfg_stride (cfg_stride[P*NLOOP*ADDR_W +: NLOOP*ADDR_W]),
      .addr       (gen_addr[P]),
      .last       (rd_last_unused[r]),
      .done       (gen_done[P])
    );
    wfpb_rd_port #(.DW(DW), .FW(FW)) port_i (
      .clk       (clk),
      .rst       (rst),
      .gnt       (gnt[P]),
      .gen_done  (gen_done[P]),
      .sram_q    (sram_q),
      .req       (req[P]),
      .out_valid (rd_valid[r]),
      .out_data  (rd_data[r*DW +: DW]),
      .out_ready (rd_ready[r])
    );
  end

  // Steer the single SRAM port to whichever logical port holds the grant.
  always_comb begin
    sram_en    = |gnt;
    sram_we    = 1'b0;
    sram_addr  = '0;
    sram_wdata = '0;
    for (int w = 0; w < NUM_WR; w++) begin
      if (gnt[w]) begin
        sram_we    = 1'b1;
        sram_addr  = gen_addr[w];
        sram_wdata = wr_wide[w];
      end
    end
    for (int r = 0; r < NUM_RD; r++) begin
      if (gnt[NUM_WR + r]) begin
        sram_addr = gen_addr[NUM_WR + r];
      end
    end
  end

  // Single-port wide memory, no reset on contents, registered read data.
  always_ff @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) begin
        mem_q[sram_addr] <= sram_wdata;
      end else begin
        sram_q <= mem_q[sram_addr];
      end
    end
  end

  assign port_done = gen_done;

  assert_write_excludes_read_R8: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (gnt[NUM_PORTS-1:NUM_WR] == '0));
endmodule

// File: tb/wf_push_buffer_tb_top.sv
`timescale 1ns/1ps
module wf_push_buffer_tb_top;
  localparam int DW = 16, FW = 4, DEPTH = 512, EXT_W = 8;
  localparam int AW = 9, NL = 3, NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NP*AW-1:0]       cfg_start;
  logic [NP*NL*EXT_W-1:0] cfg_ext;
  logic [NP*NL*AW-1:0]    cfg_stride;
  logic [1:0]             wr_valid, wr_ready, rd_valid, rd_ready;
  logic [2*DW-1:0]        wr_data, rd_data;
  logic [3:0]             port_done;

  int n_chk  = 0;
  int n_fail = 0;
  logic [3:0] rdy_seen [1:6];

  wf_push_buffer #(.DW(DW), .FW(FW), .DEPTH(DEPTH), .EXT_W(EXT_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_start  (cfg_start),
    .cfg_ext    (cfg_ext),
    .cfg_stride (cfg_stride),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_ready   (rd_ready),
    .port_done  (port_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_gen(input int p, input int start, input int e0, input int e1, input int e2,
                         input int s0, input int s1, input int s2);
    cfg_start[p*AW +: AW]             = AW'(start);
    cfg_ext[(p*NL+0)*EXT_W +: EXT_W]  = EXT_W'(e0);
    cfg_ext[(p*NL+1)*EXT_W +: EXT_W]  = EXT_W'(e1);
    cfg_ext[(p*NL+2)*EXT_W +: EXT_W]  = EXT_W'(e2);
    cfg_stride[(p*NL+0)*AW +: AW]     = AW'(s0);
    cfg_stride[(p*NL+1)*AW +: AW]     = AW'(s1);
    cfg_stride[(p*NL+2)*AW +: AW]     = AW'(s2);
  endtask

  task automatic drive_wr(input int p, input logic [15:0] base);
    int j = 0;
    int extra = 0;
    while (j < 32) begin
      @(negedge clk);
      wr_valid[p] = 1'b1;
      wr_data[p*DW +: DW] = base + 16'(j);
      #5;
      if (wr_ready[p]) j++;
    end
    // Pattern complete: further words must not be taken (R7).
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      wr_data[p*DW +: DW] = 16'hDEAD;
      #5;
      if (wr_ready[p]) extra++;
    end
    @(negedge clk);
    wr_valid[p] = 1'b0;
    chk($sformatf("R7 write port %0d accepted words after done", p), 32'(extra), 32'd0);
  endtask

  task automatic watch_ready();
    for (int s = 1; s <= 6; s++) begin
      @(negedge clk);
      #5;
      rdy_seen[s] = {2'b00, wr_ready};
    end
  endtask

  task automatic read_stream(input int p, input bit throttle);
    int idx = 0;
    int cyc = 0;
    int extra = 0;
    bit hold = 1'b0;
    logic [15:0] hd = '0;
    logic [15:0] exp;
    while (idx < 32 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      rd_ready[p] = throttle ? cyc[0] : 1'b1;
      #5;
      if (hold) begin
        chk($sformatf("R5 port %0d valid held", p), 32'(rd_valid[p]), 32'd1);
        chk($sformatf("R5 port %0d data held", p), 32'(rd_data[p*DW +: DW]), 32'(hd));
      end
      hold = rd_valid[p] && !rd_ready[p];
      hd   = rd_data[p*DW +: DW];
      if (rd_valid[p] && rd_ready[p]) begin
        if (p == 0) begin
          exp = 16'h1000 + 16'(idx);
          chk($sformatf("R2 R4 R1 read0 word %0d", idx), 32'(rd_data[p*DW +: DW]), 32'(exp));
        end else begin
          exp = 16'h2000 + 16'(4 * (7 - idx / 4) + idx % 4);
          chk($sformatf("R6 R8 read1 word %0d", idx), 32'(rd_data[p*DW +: DW]), 32'(exp));
        end
        idx++;
      end
    end
    chk($sformatf("R4 read port %0d word count", p), 32'(idx), 32'd32);
    rd_ready[p] = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      #5;
      if (rd_valid[p]) extra++;
    end
    chk($sformatf("R7 read port %0d valid after done", p), 32'(extra), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wr_valid = '0;
    wr_data  = '0;
    rd_ready = '0;
    // Phase A: fill storage through both write ports.
    set_gen(0, 0, 4, 2, 1, 1, 8, 0);     // addresses 0-3, 8-11
    set_gen(1, 4, 2, 2, 2, 1, 8, 16);    // 4,5,12,13,20,21,28,29
    set_gen(2, 300, 1, 1, 1, 0, 0, 0);
    set_gen(3, 300, 1, 1, 1, 0, 0, 0);
    repeat (3) @(posedge clk);
    chk("R1 done low during reset", 32'(port_done), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #5;
    chk("R1 write ready after reset", 32'(wr_ready), 32'd3);
    chk("R1 read valid after reset", 32'(rd_valid), 32'd0);
    chk("R1 done after reset", 32'(port_done), 32'd0);
    fork
      drive_wr(0, 16'h1000);
      drive_wr(1, 16'h2000);
      watch_ready();
    join
    for (int s = 1; s <= 4; s++) begin
      chk($sformatf("R3 ready while filling, cycle %0d", s), 32'(rdy_seen[s]), 32'd3);
    end
    chk("R9 R3 both full: write0 granted first, write1 stalled", 32'(rdy_seen[5]), 32'd1);
    chk("R9 write1 granted next", 32'(rdy_seen[6]), 32'd3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #5;
    chk("R8 R7 all four generators finished", 32'(port_done), 32'hF);
    chk("R7 write ready low after done", 32'(wr_ready), 32'd0);

    // Phase B: reset keeps storage; drain it through both read ports.
    @(negedge clk);
    rst = 1'b1;
    set_gen(0, 400, 1, 1, 1, 0, 0, 0);
    set_gen(1, 400, 1, 1, 1, 0, 0, 0);
    set_gen(2, 0, 4, 2, 1, 1, 8, 0);
    set_gen(3, 29, 2, 2, 2, -1, -8, -16);  // 29,28,21,20,13,12,5,4
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #5;
    chk("R1 done cleared by reset", 32'(port_done), 32'd0);
    chk("R1 read valid after second reset", 32'(rd_valid), 32'd0);
    chk("R1 write ready after second reset", 32'(wr_ready), 32'd3);
    fork
      read_stream(0, 1'b0);
      read_stream(1, 1'b1);
    join
    chk("R7 read generators done", 32'(port_done[3:2]), 32'd3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule